// File: doc/BRIEF.md
# Programmable Chip-Select Region Decoder

The block turns each bus access into at most one of five active-low chip selects. Every region is described by a base tag and a mask tag. Both tags cover address bits 31:12, so the smallest region is 4 KB. A region also carries an enable bit and a write-protect bit. Software fills these fields through a small register write port. Each access is checked against every enabled region at the same time. The outcome is registered and appears one cycle later as a chip select, a region index, a write strobe, a miss flag or a protection-violation flag.

Clearing mask bits above a region's size makes that region answer at several addresses. The number of copies is 2 raised to the number of cleared bits. If regions overlap, the lowest-numbered one wins. A write to a protected region is refused: no chip select and no write strobe go out, and the violation flag marks the refusal. Later cycle-timing logic uses the reported index to choose its settings.

Top module: `csdec_top`

## Requirements
- R1: After reset all chip selects are high (`cs_n` = 5'b11111), `cs_idx`, `cs_miss`, `cs_wp_viol` and `cs_wr_stb` are 0, and every region is disabled.
- R2: Region i matches when `((acc_addr[31:12] ^ base_i) & mask_i) == 0`. The outcome of an access with `acc_valid` high appears on the outputs exactly one clock later and lasts one cycle. When `acc_valid` is low, the next cycle shows all selects high and all flags low.
- R3: Bit 0 of a region's base word is its enable. A region whose enable is 0 never drives its chip select low.
- R4: When several enabled regions match, only the lowest-numbered one is selected, so at most one bit of `cs_n` is ever low.
- R5: A valid access that matches no enabled region keeps `cs_n` all high and raises `cs_miss` for one cycle, with `cs_idx` = 0.
- R6: Bit 1 of a region's base word is write protect. A write that selects a protected region keeps `cs_n` all high, keeps `cs_wr_stb` low, raises `cs_wp_viol` for one cycle and reports the region in `cs_idx`. A read of that region is served normally.
- R7: Clearing mask bits above the region size repeats the region. For example, base 0 with mask 0xF3000 answers at 0x00000000, 0x04000000, 0x08000000 and 0x0C000000 (each 16 MB), but not at 0x01000000 or 0x10000000.
- R8: The config port is `cfg_addr` = {region[2:0], sel}. With sel=0 the write goes to the base word: bits 31:12 are the base, bit 1 is write protect, bit 0 is the enable. With sel=1 it goes to the option word, whose bits 31:12 are the mask. Writes with region 5 to 7 are ignored. An access in the same cycle as a config write uses the old settings.
- R9: `cs_wr_stb` goes high together with the chip select only for a write to a matching, unprotected region. It stays low for reads.
- R10: `cs_idx` gives the number of the selected region whenever a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | 4 | {region index, word select} |
| cfg_wdata | input | 32 | Config write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access byte address |
| cs_n | output | 5 | Active-low chip selects |
| cs_idx | output | 3 | Selected region number |
| cs_wr_stb | output | 1 | Forwarded write strobe |
| cs_miss | output | 1 | Decode miss pulse |
| cs_wp_viol | output | 1 | Refused protected write pulse |

## Verification
A config write and an access can land in the same clock. In that case the access must be decoded with the settings from before the write. The bench sets up that collision by enabling a region in the same cycle as an access to that region's address. It expects a miss on that access and a hit on the access that follows. Overlapping regions combined with protection are also driven together, so that the priority winner decides whether the access is refused.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int NUM_REGIONS = 5;
  localparam int ADDR_W      = 32;
  localparam int GRAN_BITS   = 12;
  localparam int TAG_W       = ADDR_W - GRAN_BITS;
  localparam int IDX_W       = $clog2(NUM_REGIONS);
endpackage

// File: rtl/csdec_regfile.sv
module csdec_regfile
  import csdec_pkg::*;
#(
  parameter int N = NUM_REGIONS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IDX_W:0]           cfg_addr,
  input  logic [ADDR_W-1:0]        cfg_wdata,
  output logic [N-1:0][TAG_W-1:0]  base_tag,
  output logic [N-1:0][TAG_W-1:0]  mask_tag,
  output logic [N-1:0]             region_en,
  output logic [N-1:0]             region_wp
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata[GRAN_BITS-1:2];

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic hit_base, hit_mask;
    assign hit_base = cfg_we && (cfg_addr[IDX_W:1] == IDX_W'(i)) && !cfg_addr[0];
    assign hit_mask = cfg_we && (cfg_addr[IDX_W:1] == IDX_W'(i)) &&  cfg_addr[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_tag[i]  <= '0;
        region_en[i] <= 1'b0;
        region_wp[i] <= 1'b0;
      end else if (hit_base) begin
        base_tag[i]  <= cfg_wdata[ADDR_W-1:GRAN_BITS];
        region_en[i] <= cfg_wdata[0];
        region_wp[i] <= cfg_wdata[1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_tag[i] <= '0;
      else if (hit_mask) mask_tag[i] <= cfg_wdata[ADDR_W-1:GRAN_BITS];
    end
  end
endmodule

// File: rtl/csdec_match.sv
module csdec_match
  import csdec_pkg::*;
#(
  parameter int N = NUM_REGIONS
) (
  input  logic [TAG_W-1:0]         addr_tag,
  input  logic [N-1:0][TAG_W-1:0]  base_tag,
  input  logic [N-1:0][TAG_W-1:0]  mask_tag,
  input  logic [N-1:0]             region_en,
  output logic [N-1:0]             match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = region_en[i] &&
                      (((addr_tag ^ base_tag[i]) & mask_tag[i]) == '0);
  end
endmodule

// File: rtl/csdec_select.sv
module csdec_select
  import csdec_pkg::*;
#(
  parameter int N = NUM_REGIONS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [N-1:0]      match,
  input  logic [N-1:0]      region_wp,
  output logic [N-1:0]      cs_n,
  output logic [IDX_W-1:0]  cs_idx,
  output logic              cs_wr_stb,
  output logic              cs_miss,
  output logic              cs_wp_viol
);
  logic             any_hit;
  logic [IDX_W-1:0] win_idx;
  logic [N-1:0]     cs_n_d;
  logic [IDX_W-1:0] idx_d;
  logic             stb_d, miss_d, viol_d, refused;

  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    refused = acc_valid && any_hit && acc_write && region_wp[win_idx];
    cs_n_d  = '1;
    if (acc_valid && any_hit && !refused) cs_n_d[win_idx] = 1'b0;
    idx_d   = (acc_valid && any_hit) ? win_idx : '0;
    stb_d   = acc_valid && any_hit && acc_write && !refused;
    miss_d  = acc_valid && !any_hit;
    viol_d  = refused;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n       <= '1;
      cs_idx     <= '0;
      cs_wr_stb  <= 1'b0;
      cs_miss    <= 1'b0;
      cs_wp_viol <= 1'b0;
    end else begin
      cs_n       <= cs_n_d;
      cs_idx     <= idx_d;
      cs_wr_stb  <= stb_d;
      cs_miss    <= miss_d;
      cs_wp_viol <= viol_d;
    end
  end
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int N = NUM_REGIONS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W:0]    cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [N-1:0]      cs_n,
  output logic [IDX_W-1:0]  cs_idx,
  output logic              cs_wr_stb,
  output logic              cs_miss,
  output logic              cs_wp_viol
);
  logic [N-1:0][TAG_W-1:0] base_tag;
  logic [N-1:0][TAG_W-1:0] mask_tag;
  logic [N-1:0]            region_en;
  logic [N-1:0]            region_wp;
  logic [N-1:0]            match;
  logic                    unused_addr_low;

  assign unused_addr_low = ^acc_addr[GRAN_BITS-1:0];

  csdec_regfile #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .base_tag(base_tag), .mask_tag(mask_tag),
    .region_en(region_en), .region_wp(region_wp)
  );

  csdec_match #(.N(N)) u_match (
    .addr_tag(acc_addr[ADDR_W-1:GRAN_BITS]), .base_tag(base_tag),
    .mask_tag(mask_tag), .region_en(region_en), .match(match)
  );

  csdec_select #(.N(N)) u_sel (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .match(match), .region_wp(region_wp), .cs_n(cs_n), .cs_idx(cs_idx),
    .cs_wr_stb(cs_wr_stb), .cs_miss(cs_miss), .cs_wp_viol(cs_wp_viol)
  );
endmodule

// File: rtl/csdec_checker.sv
module csdec_checker #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         acc_valid,
  input logic [N-1:0] cs_n,
  input logic         cs_wr_stb,
  input logic         cs_miss,
  input logic         cs_wp_viol,
  input logic [N-1:0] region_en
);
  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (&cs_n && !cs_miss && !cs_wp_viol && !cs_wr_stb));

  assert_miss_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_miss |-> (&cs_n && !cs_wr_stb && !cs_wp_viol));

  assert_viol_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_wp_viol |-> (&cs_n && !cs_wr_stb));

  assert_strobe_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_wr_stb |-> !(&cs_n));

  for (genvar i = 0; i < N; i++) begin : g_en
    assert_enabled_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n[i] |-> $past(region_en[i]));
  end
endmodule

bind csdec_top csdec_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .cs_n(cs_n),
  .cs_wr_stb(cs_wr_stb), .cs_miss(cs_miss), .cs_wp_viol(cs_wp_viol),
  .region_en(region_en)
);

// File: tb/csdec_top_bench.sv
`timescale 1ns/1ps
module csdec_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        acc_valid, acc_write;
  logic [31:0] acc_addr;
  logic [4:0]  cs_n;
  logic [2:0]  cs_idx;
  logic        cs_wr_stb, cs_miss, cs_wp_viol;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  csdec_top u_csdec_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .cs_n(cs_n), .cs_idx(cs_idx), .cs_wr_stb(cs_wr_stb),
    .cs_miss(cs_miss), .cs_wp_viol(cs_wp_viol)
  );

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic expect_out(string req, logic [4:0] e_cs, logic [2:0] e_idx,
                            logic e_stb, logic e_miss, logic e_viol);
    check(req, "cs_n", 32'(cs_n), 32'(e_cs));
    check(req, "cs_idx", 32'(cs_idx), 32'(e_idx));
    check(req, "wr_stb", 32'(cs_wr_stb), 32'(e_stb));
    check(req, "miss", 32'(cs_miss), 32'(e_miss));
    check(req, "wp_viol", 32'(cs_wp_viol), 32'(e_viol));
  endtask

  task automatic cfg_write(int region, bit sel, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'(region), sel}; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_access(logic [31:0] addr, bit wr);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = addr; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  function automatic logic [4:0] sel_n(int i);
    return ~(5'b1 << i);
  endfunction

  task automatic t_reset;
    expect_out("R1", 5'h1F, 3'd0, 0, 0, 0);
    do_access(32'h0000_0000, 0);
    expect_out("R1", 5'h1F, 3'd0, 0, 1, 0);
  endtask

  task automatic t_basic;
    cfg_write(2, 1, 32'hFFE0_0000);
    cfg_write(2, 0, 32'h0020_0001);
    do_access(32'h0023_4560, 0);
    expect_out("R2", sel_n(2), 3'd2, 0, 0, 0);
    @(negedge clk);
    expect_out("R2", 5'h1F, 3'd0, 0, 0, 0);
    do_access(32'h003F_FFFC, 1);
    expect_out("R9", sel_n(2), 3'd2, 1, 0, 0);
    do_access(32'h0040_0000, 0);
    expect_out("R5", 5'h1F, 3'd0, 0, 1, 0);
    @(negedge clk);
    check("R5", "miss one cycle", 32'(cs_miss), 0);
  endtask

  task automatic t_enable_priority;
    cfg_write(1, 1, 32'hFFE0_0000);
    cfg_write(1, 0, 32'h0020_0000);
    do_access(32'h0021_0000, 0);
    expect_out("R3", sel_n(2), 3'd2, 0, 0, 0);
    cfg_write(1, 0, 32'h0020_0001);
    do_access(32'h0021_0000, 0);
    expect_out("R4", sel_n(1), 3'd1, 0, 0, 0);
    cfg_write(0, 1, 32'hFF00_0000);
    cfg_write(0, 0, 32'h0000_0001);
    do_access(32'h0021_0000, 1);
    expect_out("R10", sel_n(0), 3'd0, 1, 0, 0);
    cfg_write(0, 0, 32'h0);
    cfg_write(1, 0, 32'h0);
    cfg_write(2, 0, 32'h0);
    do_access(32'h0021_0000, 0);
    expect_out("R3", 5'h1F, 3'd0, 0, 1, 0);
  endtask

  task automatic t_alias;
    cfg_write(4, 1, 32'hF300_0000);
    cfg_write(4, 0, 32'h0000_0001);
    for (int k = 0; k < 4; k++) begin
      do_access(32'h0012_3000 + 32'(k) * 32'h0400_0000, 0);
      expect_out("R7", sel_n(4), 3'd4, 0, 0, 0);
    end
    do_access(32'h0100_0000, 0);
    expect_out("R7", 5'h1F, 3'd0, 0, 1, 0);
    do_access(32'h1000_0000, 0);
    expect_out("R7", 5'h1F, 3'd0, 0, 1, 0);
  endtask

  task automatic t_protect;
    cfg_write(4, 0, 32'h0000_0003);
    do_access(32'h0800_0040, 1);
    expect_out("R6", 5'h1F, 3'd4, 0, 0, 1);
    @(negedge clk);
    check("R6", "viol one cycle", 32'(cs_wp_viol), 0);
    do_access(32'h0800_0040, 0);
    expect_out("R6", sel_n(4), 3'd4, 0, 0, 0);
    cfg_write(3, 1, 32'hFFFF_F000);
    cfg_write(3, 0, 32'h0800_0001);
    do_access(32'h0800_0040, 1);
    expect_out("R4", sel_n(3), 3'd3, 1, 0, 0);
    cfg_write(3, 0, 32'h0);
  endtask

  task automatic t_cfg_port;
    cfg_write(6, 1, 32'hFFFF_F000);
    cfg_write(6, 0, 32'h2000_0001);
    do_access(32'h2000_0000, 0);
    expect_out("R8", 5'h1F, 3'd0, 0, 1, 0);
    cfg_write(1, 1, 32'hFFFF_F000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'd1, 1'b0}; cfg_wdata = 32'h3000_0001;
    acc_valid = 1'b1; acc_addr = 32'h3000_0800; acc_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    expect_out("R8", 5'h1F, 3'd0, 0, 1, 0);
    do_access(32'h3000_0800, 0);
    expect_out("R8", sel_n(1), 3'd1, 0, 0, 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    acc_valid = 0; acc_write = 0; acc_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_enable_priority();
    t_alias();
    t_protect();
    t_cfg_port();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule